// File: doc/BRIEF.md
# Boundary-Scan Wrapped Dual-Byte Transparent Latch

This block holds two independent 9-bit byte lanes, A and B. Each lane has a level-sensitive transparent latch with its own latch-enable pin, and an active-low output-enable pin that turns the lane's drivers on or off. The block reports every output as a data bus plus a per-lane drive enable. The pad ring turns that pair into a tri-state pin.

All of this sits inside a 42-cell boundary register that a test access controller operates through strobes: capture, shift, update, scan-mode select and force-off. Cells on the system inputs can only observe. Cells on the outputs and on the two internal active-high drive enables can also control. In scan mode the lane outputs and enables come from the update stage of those cells rather than from the latches.

Top module: `bscan_dual_latch`

## Requirements
- R1: In normal mode, while a lane's latch enable is 1, its data output equals its data input.
- R2: When a lane's latch enable falls to 0, the output keeps the value present just before the fall, whatever the input does later.
- R3: A lane's output-enable pin at 1 drives that lane's drive enable to 0, but the latch still accepts new data. The lane's data output keeps showing the latch contents.
- R4: The serial path from `tdi` to `tdo` is exactly 42 cells. On each shift edge `tdi` enters at bit 41 and `tdo` shows bit 0, so a 42-bit word shifted in is returned unchanged by the next 42 shifts.
- R5: A capture loads the control group as follows: bit 41 is the A output-enable pin, bit 40 is the A latch enable, and bit 39 is the inverse of the A output-enable pin. Bits 38, 37 and 36 hold the same three values for lane B.
- R6: A capture loads A inputs 0..8 into bits 35..27, B inputs 0..8 into bits 26..18, A latch contents 0..8 into bits 17..9, and B latch contents 0..8 into bits 8..0.
- R7: Capture and shift act on the rising edge of `tck`, and the update stage loads on the falling edge. Reset clears the shift and update stages to 0.
- R8: With `scan_mode` at 1, A data comes from update bits 17..9 (bit 17 is A0) and B data from bits 8..0. The A and B drive enables equal update bits 39 and 36, where 1 means drive.
- R9: With `scan_hiz` at 1, both drive enables are 0 regardless of mode, cell contents or pins.
- R10: With `scan_mode` at 0, shifting and updating the register have no effect on the data outputs or the drive enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan clock; capture and shift act on the rise, update on the fall |
| rst_n | input | 1 | Asynchronous active-low reset of the scan stages |
| tdi | input | 1 | Serial data into bit 41 |
| scan_capture | input | 1 | Load the parallel snapshot on the next rising edge |
| scan_shift | input | 1 | Shift one place toward bit 0 on the next rising edge |
| scan_update | input | 1 | Copy control cells to the update stage on the falling edge |
| scan_mode | input | 1 | 1 selects the update stage as the source of outputs and enables |
| scan_hiz | input | 1 | 1 forces both drive enables off |
| a_din | input | 9 | Lane A data input |
| b_din | input | 9 | Lane B data input |
| a_le | input | 1 | Lane A latch enable, active high |
| b_le | input | 1 | Lane B latch enable, active high |
| a_oe_n | input | 1 | Lane A output enable, active low |
| b_oe_n | input | 1 | Lane B output enable, active low |
| a_dout | output | 9 | Lane A data toward the pads |
| b_dout | output | 9 | Lane B data toward the pads |
| a_drv_en | output | 1 | Lane A drive enable (0 means high impedance) |
| b_drv_en | output | 1 | Lane B drive enable (0 means high impedance) |
| tdo | output | 1 | Serial data out, bit 0 of the register |

## Verification
The hardest state to reach is an update stage whose contents differ from what the lanes drive in normal mode. Only in that state does the falling-edge update show at the ports, and only then can a wrong source selection be told apart from a right one. The stimulus first puts distinct patterns on the lanes. It then shifts in a separate word whose enable bits disagree between lanes, and checks that normal-mode outputs do not move. It then switches to scan mode and raises the update strobe, and samples just before and just after the falling edge. A capture of asymmetric pin levels, read back through 42 shifts, confirms each field position bit by bit.

// File: rtl/bsl_pkg.sv
package bsl_pkg;
  // Which source drives a lane's data and enable.
  typedef enum logic {
    SRC_CORE = 1'b0,
    SRC_CELL = 1'b1
  } out_src_e;

  function automatic out_src_e pick_src(input logic scan_mode);
    return scan_mode ? SRC_CELL : SRC_CORE;
  endfunction

  // Final drive enable after the force-off request.
  function automatic logic gate_enable(input logic en, input logic hiz);
    return en & ~hiz;
  endfunction
endpackage

// File: rtl/bsl_byte_latch.sv
module bsl_byte_latch #(
  parameter int W = 9
) (
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Level-sensitive storage: transparent while le is high.
  always_latch begin
    if (le) q = d;
  end
endmodule

// File: rtl/bsl_out_sel.sv
module bsl_out_sel #(
  parameter int W = 9
) (
  input  logic         scan_mode,
  input  logic         hiz,
  input  logic [W-1:0] core_q,
  input  logic         oe_n,
  input  logic [W-1:0] cell_q,
  input  logic         cell_en,
  output logic [W-1:0] dout,
  output logic         drv_en
);
  import bsl_pkg::*;

  out_src_e src;
  logic     raw_en;

  always_comb begin
    src = pick_src(scan_mode);
    if (src == SRC_CELL) begin
      dout   = cell_q;
      raw_en = cell_en;
    end else begin
      dout   = core_q;
      raw_en = ~oe_n;
    end
    drv_en = gate_enable(raw_en, hiz);
  end
endmodule

// File: rtl/bsl_scan_chain.sv
module bsl_scan_chain #(
  parameter int W   = 9,
  parameter int LEN = 4 * W + 6
) (
  input  logic           tck,
  input  logic           rst_n,
  input  logic           tdi,
  input  logic           cap,
  input  logic           shift,
  input  logic           upd,
  input  logic [LEN-1:0] cap_vec,
  output logic           tdo,
  output logic           upd_en_a,
  output logic           upd_en_b,
  output logic [W-1:0]   upd_a,
  output logic [W-1:0]   upd_b
);
  localparam int EN_A_BIT  = LEN - 3;
  localparam int EN_B_BIT  = LEN - 6;
  localparam int AOUT_TOP  = 2 * W - 1;
  localparam int BOUT_TOP  = W - 1;

  logic [LEN-1:0] sr;

  // Capture/shift stage, rising edge; capture wins over shift.
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      sr <= '0;
    else if (cap)    sr <= cap_vec;
    else if (shift)  sr <= {tdi, sr[LEN-1:1]};
  end

  assign tdo = sr[0];

  // Update stage for control cells only, falling edge.
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      upd_en_a <= 1'b0;
      upd_en_b <= 1'b0;
      upd_a    <= '0;
      upd_b    <= '0;
    end else if (upd) begin
      upd_en_a <= sr[EN_A_BIT];
      upd_en_b <= sr[EN_B_BIT];
      for (int i = 0; i < W; i++) begin
        upd_a[i] <= sr[AOUT_TOP - i];
        upd_b[i] <= sr[BOUT_TOP - i];
      end
    end
  end

  // R7 capture takes the parallel snapshot on the rise
  cap_load_chk: assert property (@(posedge tck) disable iff (!rst_n)
    cap |=> sr == $past(cap_vec));

  // R4 shift moves one place, tdi entering at the top
  shift_move_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (shift && !cap) |=> (sr[LEN-1] == $past(tdi)) && (sr[LEN-2:0] == $past(sr[LEN-1:1])));

  // R7 update stage follows the enable cells on the fall
  upd_en_chk: assert property (@(negedge tck) disable iff (!rst_n)
    upd |=> (upd_en_a == $past(sr[EN_A_BIT])) && (upd_en_b == $past(sr[EN_B_BIT])));

  // R7 update stage holds without the strobe
  upd_hold_chk: assert property (@(negedge tck) disable iff (!rst_n)
    !upd |=> $stable(upd_a) && $stable(upd_b));
endmodule

// File: rtl/bscan_dual_latch.sv
module bscan_dual_latch #(
  parameter int W = 9
) (
  input  logic         tck,
  input  logic         rst_n,
  input  logic         tdi,
  input  logic         scan_capture,
  input  logic         scan_shift,
  input  logic         scan_update,
  input  logic         scan_mode,
  input  logic         scan_hiz,
  input  logic [W-1:0] a_din,
  input  logic [W-1:0] b_din,
  input  logic         a_le,
  input  logic         b_le,
  input  logic         a_oe_n,
  input  logic         b_oe_n,
  output logic [W-1:0] a_dout,
  output logic [W-1:0] b_dout,
  output logic         a_drv_en,
  output logic         b_drv_en,
  output logic         tdo
);
  localparam int LEN = 4 * W + 6;

  logic [W-1:0]   a_q, b_q;
  logic [W-1:0]   cell_a, cell_b;
  logic           cell_en_a, cell_en_b;
  logic [LEN-1:0] cap_vec;

  bsl_byte_latch #(.W(W)) lat_a (.le(a_le), .d(a_din), .q(a_q));
  bsl_byte_latch #(.W(W)) lat_b (.le(b_le), .d(b_din), .q(b_q));

  // Parallel snapshot: control group on top, lane bit 0 at the high end of each field.
  always_comb begin
    cap_vec[LEN-1] = a_oe_n;
    cap_vec[LEN-2] = a_le;
    cap_vec[LEN-3] = ~a_oe_n;
    cap_vec[LEN-4] = b_oe_n;
    cap_vec[LEN-5] = b_le;
    cap_vec[LEN-6] = ~b_oe_n;
    for (int i = 0; i < W; i++) begin
      cap_vec[4*W-1-i] = a_din[i];
      cap_vec[3*W-1-i] = b_din[i];
      cap_vec[2*W-1-i] = a_q[i];
      cap_vec[W-1-i]   = b_q[i];
    end
  end

  bsl_scan_chain #(.W(W), .LEN(LEN)) chain_i (
    .tck(tck), .rst_n(rst_n), .tdi(tdi),
    .cap(scan_capture), .shift(scan_shift), .upd(scan_update),
    .cap_vec(cap_vec), .tdo(tdo),
    .upd_en_a(cell_en_a), .upd_en_b(cell_en_b),
    .upd_a(cell_a), .upd_b(cell_b)
  );

  bsl_out_sel #(.W(W)) sel_a (
    .scan_mode(scan_mode), .hiz(scan_hiz), .core_q(a_q), .oe_n(a_oe_n),
    .cell_q(cell_a), .cell_en(cell_en_a), .dout(a_dout), .drv_en(a_drv_en)
  );

  bsl_out_sel #(.W(W)) sel_b (
    .scan_mode(scan_mode), .hiz(scan_hiz), .core_q(b_q), .oe_n(b_oe_n),
    .cell_q(cell_b), .cell_en(cell_en_b), .dout(b_dout), .drv_en(b_drv_en)
  );

  // R1 transparent lane passes its input
  a_transp_chk: assert property (@(posedge tck) disable iff (!rst_n)
    a_le |-> a_q == a_din);

  // R2 closed lane keeps its contents
  a_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (!a_le && $past(!a_le)) |-> $stable(a_q));

  // R9 force-off wins over everything
  hiz_off_chk: assert property (@(posedge tck) disable iff (!rst_n)
    scan_hiz |-> !a_drv_en && !b_drv_en);

  // R8 scan mode drives from the update stage
  mode_src_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (scan_mode && !scan_hiz) |-> (a_dout == cell_a) && (a_drv_en == cell_en_a)
                                 && (b_dout == cell_b) && (b_drv_en == cell_en_b));

  // R10 normal mode ignores the scan stages
  norm_src_chk: assert property (@(posedge tck) disable iff (!rst_n)
    (!scan_mode && !scan_hiz) |-> (a_dout == a_q) && (a_drv_en == !a_oe_n)
                                  && (b_dout == b_q) && (b_drv_en == !b_oe_n));
endmodule

// File: tb/bscan_dual_latch_tb_top.sv
module bscan_dual_latch_tb_top;
  logic tck = 1'b0;
  logic rst_n = 1'b0;
  logic tdi = 1'b0, sc_cap = 1'b0, sc_shift = 1'b0, sc_upd = 1'b0;
  logic sc_mode = 1'b0, sc_hiz = 1'b0;
  logic [8:0] a_din = '0, b_din = '0;
  logic a_le = 1'b1, b_le = 1'b1, a_oe_n = 1'b0, b_oe_n = 1'b0;
  logic [8:0] a_dout, b_dout;
  logic a_drv_en, b_drv_en, tdo;

  int checks = 0;
  int fails  = 0;

  always #4 tck = ~tck;

  bscan_dual_latch dut_i (
    .tck(tck), .rst_n(rst_n), .tdi(tdi),
    .scan_capture(sc_cap), .scan_shift(sc_shift), .scan_update(sc_upd),
    .scan_mode(sc_mode), .scan_hiz(sc_hiz),
    .a_din(a_din), .b_din(b_din), .a_le(a_le), .b_le(b_le),
    .a_oe_n(a_oe_n), .b_oe_n(b_oe_n),
    .a_dout(a_dout), .b_dout(b_dout),
    .a_drv_en(a_drv_en), .b_drv_en(b_drv_en), .tdo(tdo)
  );

  // {le, oe_n, din, expected dout, expected drive enable} for lane A
  localparam logic [20:0] TBL [9] = '{
    {1'b1, 1'b0, 9'h1A5, 9'h1A5, 1'b1},
    {1'b1, 1'b0, 9'h05A, 9'h05A, 1'b1},
    {1'b0, 1'b0, 9'h05A, 9'h05A, 1'b1},
    {1'b0, 1'b0, 9'h0FF, 9'h05A, 1'b1},
    {1'b0, 1'b1, 9'h0FF, 9'h05A, 1'b0},
    {1'b1, 1'b1, 9'h133, 9'h133, 1'b0},
    {1'b1, 1'b1, 9'h0C3, 9'h0C3, 1'b0},
    {1'b0, 1'b1, 9'h0C3, 9'h0C3, 1'b0},
    {1'b0, 1'b0, 9'h111, 9'h0C3, 1'b1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge tck);
    #2;
  endtask

  task automatic shift42(input logic [41:0] vin, output logic [41:0] vout);
    for (int i = 0; i < 42; i++) begin
      tdi = vin[i];
      sc_shift = 1'b1;
      #1 vout[i] = tdo;
      step();
    end
    sc_shift = 1'b0;
  endtask

  function automatic logic [8:0] rev9(input logic [8:0] x);
    logic [8:0] r;
    for (int i = 0; i < 9; i++) r[8-i] = x[i];
    return r;
  endfunction

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [41:0] v, junk, exp_v, pat;
    step(); step();
    rst_n = 1'b1;
    step();
    // R7 reset state: register empty, update stage zero
    chk("R7 tdo after reset", tdo, 0);
    sc_mode = 1'b1;
    #1;
    chk("R7 update stage data reset", {a_dout, b_dout}, 0);
    chk("R7 update stage enables reset", {a_drv_en, b_drv_en}, 0);
    sc_mode = 1'b0;
    step();

    // R1 R2 R3 table walk on lane A
    for (int k = 0; k < 9; k++) begin
      {a_le, a_oe_n, a_din} = TBL[k][20:10];
      #1;
      chk($sformatf("R1/R2/R3 lane A row %0d dout", k), a_dout, TBL[k][9:1]);
      chk($sformatf("R3 lane A row %0d enable", k), a_drv_en, TBL[k][0]);
      step();
    end

    // R2 lane B hold
    b_din = 9'h0AA; step();
    b_le = 1'b0; step();
    b_din = 9'h155; #1;
    chk("R2 lane B holds", b_dout, 9'h0AA);
    chk("R3 lane B drives", b_drv_en, 1);
    step();

    // R5 R6 capture of asymmetric levels
    a_le = 1'b1; a_din = 9'h1A5; a_oe_n = 1'b0;
    b_le = 1'b1; b_din = 9'h04B; b_oe_n = 1'b1;
    step();
    sc_cap = 1'b1; step(); sc_cap = 1'b0;
    shift42('0, v);
    exp_v = {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0,
             rev9(9'h1A5), rev9(9'h04B), rev9(9'h1A5), rev9(9'h04B)};
    chk("R5 control group", v[41:36], exp_v[41:36]);
    chk("R6 lane A inputs", v[35:27], exp_v[35:27]);
    chk("R6 lane B inputs", v[26:18], exp_v[26:18]);
    chk("R6 output cells", v[17:0], exp_v[17:0]);

    // R4 chain length round trip
    pat = 42'h3_96A5_F1E0_C3;
    shift42(pat, junk);
    shift42('0, v);
    chk("R4 42-cell round trip", v, pat);

    // R8 load scan word; R10 normal outputs untouched
    v = {3'b001, 3'b000, 18'b0, rev9(9'h16C), rev9(9'h093)};
    shift42(v, junk);
    sc_upd = 1'b1; step(); sc_upd = 1'b0;
    #1;
    chk("R10 normal A data unaffected", a_dout, 9'h1A5);
    chk("R10 normal enables unaffected", {a_drv_en, b_drv_en}, 2'b10);
    chk("R10 normal B data unaffected", b_dout, 9'h04B);
    // reload update stage to zero, then show the falling-edge load in scan mode
    shift42('0, junk);
    sc_upd = 1'b1; step(); sc_upd = 1'b0;
    shift42(v, junk);
    sc_mode = 1'b1;
    sc_upd = 1'b1;
    #1 chk("R7 no update before falling edge", a_dout, 0);
    #2 chk("R7 update on falling edge", a_dout, 9'h16C);
    @(posedge tck); #2; sc_upd = 1'b0;
    #1;
    chk("R8 scan A data", a_dout, 9'h16C);
    chk("R8 scan B data", b_dout, 9'h093);
    chk("R8 scan enables from cells", {a_drv_en, b_drv_en}, 2'b10);

    // R9 force-off in both modes
    sc_hiz = 1'b1; #1;
    chk("R9 force-off in scan mode", {a_drv_en, b_drv_en}, 0);
    sc_mode = 1'b0; #1;
    chk("R9 force-off in normal mode", {a_drv_en, b_drv_en}, 0);
    sc_hiz = 1'b0; #1;
    chk("R10 normal restored", {a_dout, a_drv_en}, {9'h1A5, 1'b1});
    step();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule